// File: doc/BRIEF.md
# Neutral-Point Balancing Selector for Three-Level Space Vectors

This block sits between the vector sequencer and the gate pattern stage of a three-level, neutral-point-clamped inverter controller. Each PWM period the sequencer names a switching state as a triple of per-phase levels. The block sorts every one of the 27 possible triples into a vector class. When the triple is a small vector, two switching states give the same line voltage. One state ties the neutral point toward the upper capacitor and charges it. The other, which is one level lower on every phase, discharges it. The block picks between the two.

The choice comes from the signed product of the measured capacitor voltage difference and the load current direction. A hysteresis band of half-width `HYST` keeps the choice from chattering. Zero, medium and large vectors have no useful partner, so they go through unchanged. The block samples its inputs only on the period strobe, so the applied state never moves within a switching cycle.

Top module: `np_balance_sel`

## Requirements
- R1: Each phase level is a 2-bit code: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. The code 2'b10 is read as 0. The applied triple is always written back in the three legal codes.
- R2: `class_o` carries the class of the applied triple: 0 = zero, 1 = upper small, 2 = lower small, 3 = medium, 4 = large. It never holds any other value.
- R3: A request that is a zero vector (all phases equal), a medium vector (all three levels present) or a large vector (+1 and -1 present, no 0) is applied unchanged.
- R4: A small request is either an upper member (levels {0,+1} only) or a lower member (levels {-1,0} only). The lower member equals the upper member minus one level on each phase. Either member selects the same pair, and the output is the member chosen by the balancing rule.
- R5: Let P = `vdiff_i` if `cur_dir_i` is 1, else -`vdiff_i`. If P > `HYST` at a strobe, the lower member is chosen.
- R6: If P < -`HYST` at a strobe, the upper member is chosen.
- R7: If -`HYST` <= P <= `HYST` at a strobe, the previous choice is kept. Both bounds are inclusive.
- R8: Outputs and the stored choice change only at a clock edge where `strobe_i` is high. The new values appear one edge after the strobe is sampled.
- R9: After reset the applied triple is (0,0,0), `class_o` is 0, and the stored choice is upper.
- R10: The stored choice is updated at every strobe, including strobes that request a zero, medium or large vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | PWM period strobe; samples the request |
| req_a_i | input | 2 | Requested level, phase a |
| req_b_i | input | 2 | Requested level, phase b |
| req_c_i | input | 2 | Requested level, phase c |
| vdiff_i | input | DW | Signed capacitor voltage difference |
| cur_dir_i | input | 1 | Load current direction (1 keeps the sign of vdiff_i) |
| app_a_o | output | 2 | Applied level, phase a |
| app_b_o | output | 2 | Applied level, phase b |
| app_c_o | output | 2 | Applied level, phase c |
| class_o | output | 3 | Class code of the applied triple |

## Verification
A wrong stored choice is invisible until a small vector is requested while the imbalance sits inside the band. Then the wrong pair member shows at the outputs one edge after that strobe. For this reason the sweeps run in-band scenarios right after out-of-band ones, in both directions, and step P across both band edges. A misclassification shows on the very next strobe of that triple, either as a changed medium or large state or as a wrong class code. Every one of the 64 input encodings is swept under each imbalance scenario, so such an error appears within one sweep.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;
  localparam int unsigned NPH = 3;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_POS = 2'b01;
  localparam lvl_t LVL_ZER = 2'b00;
  localparam lvl_t LVL_NEG = 2'b11;

  typedef enum logic [2:0] {
    VC_ZERO  = 3'd0,
    VC_SM_UP = 3'd1,
    VC_SM_LO = 3'd2,
    VC_MED   = 3'd3,
    VC_LARGE = 3'd4
  } vclass_e;

  // the unused code reads as the zero level
  function automatic lvl_t norm_lvl(lvl_t x);
    return (x == 2'b10) ? LVL_ZER : x;
  endfunction
endpackage

// File: rtl/np_vec_classify.sv
module np_vec_classify
  import np_bal_pkg::*;
#(
  parameter int unsigned NP = NPH
) (
  input  logic [NP-1:0][1:0] req_i,
  output logic [NP-1:0][1:0] canon_o,
  output logic [NP-1:0][1:0] partner_o,
  output vclass_e            cls_o
);
  logic [NP-1:0] is_p, is_z, is_n;

  for (genvar g = 0; g < NP; g++) begin : g_ph
    assign canon_o[g]   = norm_lvl(req_i[g]);
    assign is_p[g]      = (canon_o[g] == LVL_POS);
    assign is_z[g]      = (canon_o[g] == LVL_ZER);
    assign is_n[g]      = (canon_o[g] == LVL_NEG);
    // other member of a small pair: one level down from upper, one up from lower
    assign partner_o[g] = (cls_o == VC_SM_UP) ? canon_o[g] - 2'b01
                                              : canon_o[g] + 2'b01;
  end

  always_comb begin
    unique case ({|is_p, |is_z, |is_n})
      3'b110:  cls_o = VC_SM_UP;
      3'b011:  cls_o = VC_SM_LO;
      3'b111:  cls_o = VC_MED;
      3'b101:  cls_o = VC_LARGE;
      default: cls_o = VC_ZERO;
    endcase
  end
endmodule

// File: rtl/np_hyst_ctrl.sv
module np_hyst_ctrl #(
  parameter int DW   = 12,
  parameter int HYST = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [DW-1:0] vdiff_i,
  input  logic                 cur_dir_i,
  output logic                 pick_lo_o
);
  localparam int PW = DW + 1;
  localparam logic signed [PW-1:0] H_POS = PW'(HYST);
  localparam logic signed [PW-1:0] H_NEG = -H_POS;

  logic signed [PW-1:0] vext, prod;
  logic                 pick_q;

  assign vext = {vdiff_i[DW-1], vdiff_i};
  assign prod = cur_dir_i ? vext : -vext;

  always_comb begin
    if (prod > H_POS)      pick_lo_o = 1'b1;
    else if (prod < H_NEG) pick_lo_o = 1'b0;
    else                   pick_lo_o = pick_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pick_q <= 1'b0;
    else if (upd_i) pick_q <= pick_lo_o;
  end
endmodule

// File: rtl/np_balance_sel.sv
module np_balance_sel
  import np_bal_pkg::*;
#(
  parameter int DW   = 12,
  parameter int HYST = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic [1:0]           req_a_i,
  input  logic [1:0]           req_b_i,
  input  logic [1:0]           req_c_i,
  input  logic signed [DW-1:0] vdiff_i,
  input  logic                 cur_dir_i,
  output logic [1:0]           app_a_o,
  output logic [1:0]           app_b_o,
  output logic [1:0]           app_c_o,
  output logic [2:0]           class_o
);
  logic [NPH-1:0][1:0] req_v, canon, partner, up_mem, lo_mem, sel_v, app_q;
  vclass_e             cls, sel_cls, cls_q;
  logic                pick_lo, is_small;

  assign req_v = {req_c_i, req_b_i, req_a_i};

  np_vec_classify #(.NP(NPH)) u_cls (
    .req_i     (req_v),
    .canon_o   (canon),
    .partner_o (partner),
    .cls_o     (cls)
  );

  np_hyst_ctrl #(.DW(DW), .HYST(HYST)) u_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (strobe_i),
    .vdiff_i   (vdiff_i),
    .cur_dir_i (cur_dir_i),
    .pick_lo_o (pick_lo)
  );

  always_comb begin
    is_small = (cls == VC_SM_UP) || (cls == VC_SM_LO);
    up_mem   = (cls == VC_SM_UP) ? canon : partner;
    lo_mem   = (cls == VC_SM_LO) ? canon : partner;
    if (is_small) begin
      sel_v   = pick_lo ? lo_mem : up_mem;
      sel_cls = pick_lo ? VC_SM_LO : VC_SM_UP;
    end else begin
      sel_v   = canon;
      sel_cls = cls;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q <= '0;
      cls_q <= VC_ZERO;
    end else if (strobe_i) begin
      app_q <= sel_v;
      cls_q <= sel_cls;
    end
  end

  assign app_a_o = app_q[0];
  assign app_b_o = app_q[1];
  assign app_c_o = app_q[2];
  assign class_o = cls_q;
endmodule

// File: rtl/np_balance_sel_chk.sv
module np_balance_sel_chk #(
  parameter int DW   = 12,
  parameter int HYST = 40
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 strobe_i,
  input logic [1:0]           req_a_i,
  input logic [1:0]           req_b_i,
  input logic [1:0]           req_c_i,
  input logic signed [DW-1:0] vdiff_i,
  input logic                 cur_dir_i,
  input logic [1:0]           app_a_o,
  input logic [1:0]           app_b_o,
  input logic [1:0]           app_c_o,
  input logic [2:0]           class_o
);
  logic signed [DW:0] p_val;
  logic [5:0]         req_n, app_all;
  logic               hp, hz, hn, sm_req;

  function automatic logic [1:0] fix(logic [1:0] x);
    return (x == 2'b10) ? 2'b00 : x;
  endfunction

  assign p_val   = cur_dir_i ? DW'(vdiff_i) : -(DW+1)'(vdiff_i);
  assign req_n   = {fix(req_c_i), fix(req_b_i), fix(req_a_i)};
  assign app_all = {app_c_o, app_b_o, app_a_o};
  assign hp      = (req_n[1:0] == 2'b01) || (req_n[3:2] == 2'b01) || (req_n[5:4] == 2'b01);
  assign hz      = (req_n[1:0] == 2'b00) || (req_n[3:2] == 2'b00) || (req_n[5:4] == 2'b00);
  assign hn      = (req_n[1:0] == 2'b11) || (req_n[3:2] == 2'b11) || (req_n[5:4] == 2'b11);
  assign sm_req  = hz && (hp != hn);

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (class_o == 3'd0 && app_all == 6'd0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable({app_all, class_o}));

  p_class_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o <= 3'd4);

  p_passthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !sm_req |=> app_all == $past(req_n));

  p_lo_pick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && sm_req && (p_val > (DW+1)'(HYST)) |=> class_o == 3'd2);

  p_up_pick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && sm_req && (p_val < -(DW+1)'(HYST)) |=> class_o == 3'd1);

  p_small_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == 3'd1 |-> (app_a_o != 2'b11 && app_b_o != 2'b11 && app_c_o != 2'b11)) and
    (class_o == 3'd2 |-> (app_a_o != 2'b01 && app_b_o != 2'b01 && app_c_o != 2'b01)));
endmodule

bind np_balance_sel np_balance_sel_chk #(.DW(DW), .HYST(HYST)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (strobe_i),
  .req_a_i   (req_a_i),
  .req_b_i   (req_b_i),
  .req_c_i   (req_c_i),
  .vdiff_i   (vdiff_i),
  .cur_dir_i (cur_dir_i),
  .app_a_o   (app_a_o),
  .app_b_o   (app_b_o),
  .app_c_o   (app_c_o),
  .class_o   (class_o)
);

// File: tb/np_balance_sel_tb_top.sv
`timescale 1ns/1ps
module np_balance_sel_tb_top;
  localparam int DW   = 12;
  localparam int HYST = 40;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 strobe = 1'b0;
  logic [1:0]           ra = '0, rb = '0, rc = '0;
  logic signed [DW-1:0] vd = '0;
  logic                 dir = 1'b0;
  logic [1:0]           aa, ab, ac;
  logic [2:0]           cls;

  int n_chk = 0, n_fail = 0;
  bit pick_m = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  np_balance_sel #(.DW(DW), .HYST(HYST)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe),
    .req_a_i(ra), .req_b_i(rb), .req_c_i(rc),
    .vdiff_i(vd), .cur_dir_i(dir),
    .app_a_o(aa), .app_b_o(ab), .app_c_o(ac), .class_o(cls)
  );

  function automatic int dec(logic [1:0] x);
    return (x == 2'b01) ? 1 : ((x == 2'b11) ? -1 : 0);
  endfunction

  function automatic logic [1:0] enc(int v);
    return (v > 0) ? 2'b01 : ((v < 0) ? 2'b11 : 2'b00);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one strobe; model per R1..R7, R10; outputs sampled at the next negedge (R8)
  task automatic apply(logic [1:0] a, logic [1:0] b, logic [1:0] c, int v, bit d);
    int  dv[3];
    int  prod, ecls;
    bit  hp, hz, hn, sup, slo;
    string tag;
    @(negedge clk);
    ra = a; rb = b; rc = c; vd = DW'(v); dir = d; strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0;
    dv[0] = dec(a); dv[1] = dec(b); dv[2] = dec(c);
    hp = 0; hz = 0; hn = 0;
    for (int i = 0; i < 3; i++) begin
      if (dv[i] > 0) hp = 1; else if (dv[i] < 0) hn = 1; else hz = 1;
    end
    prod = d ? v : -v;
    if (prod > HYST) pick_m = 1'b1;
    else if (prod < -HYST) pick_m = 1'b0;
    sup = hp && hz && !hn;
    slo = hn && hz && !hp;
    if (sup || slo) ecls = pick_m ? 2 : 1;
    else if (hp && hz && hn) ecls = 3;
    else if (hp && hn) ecls = 4;
    else ecls = 0;
    if (sup && pick_m) for (int i = 0; i < 3; i++) dv[i] -= 1;
    if (slo && !pick_m) for (int i = 0; i < 3; i++) dv[i] += 1;
    if (sup || slo) tag = (prod > HYST) ? "R5" : ((prod < -HYST) ? "R6" : "R7");
    else tag = "R3";
    chk($sformatf("R2 class req=%b%b%b P=%0d", c, b, a, prod), int'(cls), ecls);
    chk($sformatf("%s R1 R4 triple req=%b%b%b P=%0d", tag, c, b, a, prod),
        int'({ac, ab, aa}), int'({enc(dv[2]), enc(dv[1]), enc(dv[0])}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    int v_sc[3], d_sc[3];
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 class in reset", int'(cls), 0);
    chk("R9 triple in reset", int'({ac, ab, aa}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 class after release", int'(cls), 0);
    // R9: stored choice starts upper; in-band request of lower member 0-1-1
    apply(2'b00, 2'b11, 2'b11, 0, 1'b1);
    chk("R9 initial choice upper", int'(cls), 1);

    // near-exhaustive sweep of all 64 encodings under three scenarios
    v_sc[0] = 100; d_sc[0] = 1;   // P = +100 -> lower
    v_sc[1] = 100; d_sc[1] = 0;   // P = -100 -> upper
    v_sc[2] = 40;  d_sc[2] = 1;   // P = +40 in band -> keep upper
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 64; k++)
        apply(k[1:0], k[3:2], k[5:4], v_sc[s], d_sc[s][0]);

    // band edges (R5, R6, R7) on pair 110 / 00-1
    apply(2'b01, 2'b01, 2'b00, -100, 1'b1);
    apply(2'b01, 2'b01, 2'b00, 40, 1'b1);
    chk("R7 P=+HYST keeps upper", int'(cls), 1);
    apply(2'b00, 2'b00, 2'b11, 41, 1'b1);
    chk("R5 P=HYST+1 picks lower", int'(cls), 2);
    apply(2'b01, 2'b01, 2'b00, -40, 1'b1);
    chk("R7 P=-HYST keeps lower", int'(cls), 2);
    apply(2'b00, 2'b00, 2'b11, -41, 1'b1);
    chk("R6 P=-HYST-1 picks upper", int'(cls), 1);
    apply(2'b00, 2'b00, 2'b11, -41, 1'b0);
    chk("R5 direction flips sign", int'(cls), 2);
    apply(2'b00, 2'b01, 2'b00, -2048, 1'b0);
    chk("R5 most negative vdiff, dir 0", int'(cls), 2);

    // R8: no strobe, inputs move, outputs hold
    held = {ac, ab, aa};
    for (int i = 0; i < 6; i++) begin
      ra = 2'(i); rb = 2'(i + 1); rc = 2'b11; vd = DW'(-500); dir = 1'b1;
      @(negedge clk);
      chk("R8 triple holds without strobe", int'({ac, ab, aa}), int'(held));
      chk("R8 class holds without strobe", int'(cls), 2);
    end
    // R8: stored choice untouched by those cycles (still lower)
    apply(2'b01, 2'b00, 2'b00, 0, 1'b1);
    chk("R8 choice unchanged without strobe", int'(cls), 2);

    // R10: non-small strobes still move the choice
    apply(2'b01, 2'b11, 2'b11, -100, 1'b1);
    apply(2'b00, 2'b00, 2'b11, 0, 1'b1);
    chk("R10 large strobe set upper", int'(cls), 1);
    apply(2'b01, 2'b00, 2'b11, 100, 1'b1);
    apply(2'b01, 2'b00, 2'b00, 0, 1'b1);
    chk("R10 medium strobe set lower", int'(cls), 2);
    apply(2'b00, 2'b00, 2'b00, -100, 1'b1);
    apply(2'b11, 2'b11, 2'b00, 0, 1'b1);
    chk("R10 zero strobe set upper", int'(cls), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule